// File: doc/BRIEF.md
# DSD Input Port Selector

This block takes one-bit direct-stream audio for a left and a right channel, together with the bit clock that times both streams, and turns them into 32-bit parallel words. The three signals may arrive on either of two shared pin groups, and a select input picks which group is used. The pins are asynchronous to the block's own clock. They pass through a synchroniser, and an edge detector finds the sampling edge of the bit clock. A polarity input chooses whether the rising or the falling edge is the sampling edge.

Two input formats are supported. In normal format every sampling edge carries a new bit. In phase-modulation format the stream arrives as D0, D1, D1, D2, D2, D3 and so on, so every data bit after the first fills two bit periods. The block keeps the first sample and then alternate samples. A rate input gives the bit-clock ratio to the sample rate, and the block raises a one-cycle sample tick once per sample period of bit-clock edges.

A small state machine controls capture. ST_FLUSH discards input for a short settling time after reset or after any configuration change. ST_KEEP stores the next sampled bit. ST_SKIP passes over the repeated sample in phase-modulation format. The transitions are T_RECONFIG (any state to ST_FLUSH when a configuration input changes), T_FLUSH_DONE (ST_FLUSH to ST_KEEP when settling ends), T_PAIR_FIRST (ST_KEEP to ST_SKIP on a stored edge in phase-modulation format) and T_PAIR_SECOND (ST_SKIP to ST_KEEP on the next edge). In normal format the machine stays in ST_KEEP.

Top module: `dsd_port_select`

## Requirements
- R1: With `path_sel` = 0, `grp0_clk` is the bit clock, `grp0_left` is the left data and `grp0_right` is the right data.
- R2: With `path_sel` = 1, `grp1_clk`, `grp1_left` and `grp1_right` supply bit clock, left and right data. The unselected group has no effect on the words or strobes.
- R3: With `clk_invert` = 0 data is sampled on rising bit-clock edges. With `clk_invert` = 1 it is sampled on falling edges.
- R4: With `pm_mode` = 0 every sampling edge stores one bit per channel. Bits are packed MSB-first, so the first stored bit of a word ends up in bit 31.
- R5: `word_valid` is a one-cycle pulse after every 32 stored bits. It rises in the third clock cycle after the pin edge that carries the 32nd bit, and `left_word`/`right_word` show the new word in that same cycle.
- R6: With `pm_mode` = 1, after settling, the block stores the samples at positions 0, 2, 4, … and drops the samples at odd positions. A stream D0, D1, D1, D2, D2, … therefore yields D0, D1, D2, ….
- R7: `fs_tick` pulses once for every N sampling edges, counted from the end of settling. N is 64, 128 or 256 for `rate_sel` = 00, 01 or 10.
- R8: `rate_sel` = 11 behaves as 00 (N = 64).
- R9: A change on any configuration input (`path_sel`, `clk_invert`, `pm_mode`, `rate_sel`) discards the partial word and the tick count. The last complete words are held until a new full word of 32 bits is stored.
- R10: After reset `left_word` and `right_word` are zero and `word_valid` and `fs_tick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, well above the bit-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| path_sel | input | 1 | Pin group select (0: group 0, 1: group 1) |
| clk_invert | input | 1 | Sampling edge (0: rising, 1: falling) |
| pm_mode | input | 1 | Phase-modulation input format |
| rate_sel | input | 2 | Bit-clock ratio: 00=64, 01=128, 10=256, 11=64 |
| grp0_clk | input | 1 | Group 0 bit clock |
| grp0_left | input | 1 | Group 0 left data |
| grp0_right | input | 1 | Group 0 right data |
| grp1_clk | input | 1 | Group 1 bit clock |
| grp1_left | input | 1 | Group 1 left data |
| grp1_right | input | 1 | Group 1 right data |
| left_word | output | 32 | Last complete left word |
| right_word | output | 32 | Last complete right word |
| word_valid | output | 1 | One-cycle strobe for a new word pair |
| fs_tick | output | 1 | One-cycle strobe per sample period |

## Verification
A pin edge reaches the outputs after two synchroniser stages and one edge-history register, so `word_valid` and the new words appear in the third clock cycle after the edge. The bench drives each edge at a falling clock edge and then counts rising edges. It checks that the strobe is still low one cycle early and that the strobe and the words are correct exactly in the third cycle. Tick and word counts are read only after several idle cycles, once any pulse still in the pipeline has landed. After every configuration change the bench holds the bit clock idle for longer than the flush time before it sends the first edge.

// File: rtl/dsd_sel_pkg.sv
package dsd_sel_pkg;

    typedef enum logic [1:0] {
        ST_FLUSH = 2'd0,
        ST_KEEP  = 2'd1,
        ST_SKIP  = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic       path;
        logic       inv;
        logic       pm;
        logic [1:0] rate;
    } dsd_cfg_t;

endpackage

// File: rtl/dsd_pin_mux.sv
module dsd_pin_mux (
    input  logic sel,
    input  logic g0_clk,
    input  logic g0_left,
    input  logic g0_right,
    input  logic g1_clk,
    input  logic g1_left,
    input  logic g1_right,
    output logic raw_clk,
    output logic raw_left,
    output logic raw_right
);

    // Pin group routing: group 1 when sel is high, group 0 otherwise
    always_comb begin
        if (sel) begin
            raw_clk   = g1_clk;
            raw_left  = g1_left;
            raw_right = g1_right;
        end else begin
            raw_clk   = g0_clk;
            raw_left  = g0_left;
            raw_right = g0_right;
        end
    end

endmodule

// File: rtl/dsd_edge_sync.sv
module dsd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inv,
    input  logic raw_clk,
    input  logic raw_left,
    input  logic raw_right,
    output logic samp_edge,
    output logic bit_left,
    output logic bit_right
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] c_sync, l_sync, r_sync;
    logic         c_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_sync <= '0;
            l_sync <= '0;
            r_sync <= '0;
            c_prev <= 1'b0;
        end else begin
            c_sync <= {c_sync[TOP-1:0], raw_clk};
            l_sync <= {l_sync[TOP-1:0], raw_left};
            r_sync <= {r_sync[TOP-1:0], raw_right};
            c_prev <= c_sync[TOP];
        end
    end

    // Rising edge when inv is low, falling edge when inv is high
    always_comb begin
        if (inv) samp_edge = c_prev & ~c_sync[TOP];
        else     samp_edge = ~c_prev & c_sync[TOP];
    end

    assign bit_left  = l_sync[TOP];
    assign bit_right = r_sync[TOP];

endmodule

// File: rtl/dsd_word_packer.sv
module dsd_word_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              bit_left,
    input  logic              bit_right,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              word_valid
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [WORD_W-2:0] acc_l, acc_r;
    logic [CNT_W-1:0]  fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_l      <= '0;
            acc_r      <= '0;
            fill_q     <= '0;
            left_word  <= '0;
            right_word <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (clear) begin
                fill_q <= '0;
            end else if (shift) begin
                acc_l <= {acc_l[WORD_W-3:0], bit_left};
                acc_r <= {acc_r[WORD_W-3:0], bit_right};
                if (fill_q == LAST_IDX) begin
                    fill_q     <= '0;
                    left_word  <= {acc_l, bit_left};
                    right_word <= {acc_r, bit_right};
                    word_valid <= 1'b1;
                end else begin
                    fill_q <= fill_q + 1'b1;
                end
            end
        end
    end

    AST_VALID_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R5

    AST_CLEAR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !word_valid); // R9

endmodule

// File: rtl/dsd_port_select.sv
module dsd_port_select
    import dsd_sel_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int BASE_RATIO  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              path_sel,
    input  logic              clk_invert,
    input  logic              pm_mode,
    input  logic [1:0]        rate_sel,
    input  logic              grp0_clk,
    input  logic              grp0_left,
    input  logic              grp0_right,
    input  logic              grp1_clk,
    input  logic              grp1_left,
    input  logic              grp1_right,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              word_valid,
    output logic              fs_tick
);

    localparam int FLUSH_CYC = SYNC_STAGES + 2;
    localparam int FLUSH_W   = $clog2(FLUSH_CYC + 1);
    localparam int RATE_W    = $clog2(4 * BASE_RATIO);
    localparam logic [FLUSH_W-1:0] FLUSH_END = FLUSH_W'(FLUSH_CYC - 1);

    dsd_cfg_t cfg_in, cfg_q;
    logic     cfg_change;

    cap_state_e state_q, state_d;
    logic [FLUSH_W-1:0] flush_cnt;

    logic raw_clk, raw_left, raw_right;
    logic samp_edge, bit_left, bit_right;
    logic capture, count_edge, flush;

    logic [RATE_W-1:0] fs_cnt;
    logic [RATE_W-1:0] fs_last;

    assign cfg_in     = '{path: path_sel, inv: clk_invert, pm: pm_mode, rate: rate_sel};
    assign cfg_change = (cfg_in != cfg_q);

    dsd_pin_mux u_mux (
        .sel       (cfg_q.path),
        .g0_clk    (grp0_clk),
        .g0_left   (grp0_left),
        .g0_right  (grp0_right),
        .g1_clk    (grp1_clk),
        .g1_left   (grp1_left),
        .g1_right  (grp1_right),
        .raw_clk   (raw_clk),
        .raw_left  (raw_left),
        .raw_right (raw_right)
    );

    dsd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv       (cfg_q.inv),
        .raw_clk   (raw_clk),
        .raw_left  (raw_left),
        .raw_right (raw_right),
        .samp_edge (samp_edge),
        .bit_left  (bit_left),
        .bit_right (bit_right)
    );

    // Ratio decode; the spare code falls back to the base ratio
    function automatic logic [RATE_W-1:0] ratio_last(input logic [1:0] code);
        logic [RATE_W-1:0] r;
        unique case (code)
            2'b01:   r = RATE_W'(2 * BASE_RATIO - 1);
            2'b10:   r = RATE_W'(4 * BASE_RATIO - 1);
            default: r = RATE_W'(BASE_RATIO - 1);
        endcase
        return r;
    endfunction

    assign fs_last = ratio_last(cfg_q.rate);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg_change) begin
            state_d = ST_FLUSH;                                   // T_RECONFIG
        end else begin
            unique case (state_q)
                ST_FLUSH: if (flush_cnt == FLUSH_END) state_d = ST_KEEP;   // T_FLUSH_DONE
                ST_KEEP:  if (samp_edge && cfg_q.pm)  state_d = ST_SKIP;   // T_PAIR_FIRST
                ST_SKIP:  if (samp_edge)              state_d = ST_KEEP;   // T_PAIR_SECOND
                default:  state_d = ST_FLUSH;
            endcase
        end
    end

    // State register with settling counter and configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_FLUSH;
            flush_cnt <= '0;
            cfg_q     <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_in;
            if (state_q != ST_FLUSH || cfg_change) flush_cnt <= '0;
            else                                   flush_cnt <= flush_cnt + 1'b1;
        end
    end

    // Output decode of the state machine
    always_comb begin
        flush      = 1'b0;
        capture    = 1'b0;
        count_edge = 1'b0;
        unique case (state_q)
            ST_FLUSH: flush = 1'b1;
            ST_KEEP: begin
                capture    = samp_edge;
                count_edge = samp_edge;
            end
            ST_SKIP:  count_edge = samp_edge;
            default:  flush = 1'b1;
        endcase
    end

    dsd_word_packer #(.WORD_W(WORD_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (flush),
        .shift      (capture),
        .bit_left   (bit_left),
        .bit_right  (bit_right),
        .left_word  (left_word),
        .right_word (right_word),
        .word_valid (word_valid)
    );

    // Sample-period counter over all sampling edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_cnt  <= '0;
            fs_tick <= 1'b0;
        end else begin
            fs_tick <= 1'b0;
            if (flush) begin
                fs_cnt <= '0;
            end else if (count_edge) begin
                if (fs_cnt >= fs_last) begin
                    fs_cnt  <= '0;
                    fs_tick <= 1'b1;
                end else begin
                    fs_cnt <= fs_cnt + 1'b1;
                end
            end
        end
    end

    AST_NORMAL_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.pm |-> state_q != ST_SKIP); // R4

    AST_PM_PAIR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEEP && samp_edge && cfg_q.pm && !cfg_change) |=> state_q == ST_SKIP); // R6

    AST_PM_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP && samp_edge && !cfg_change) |=> state_q == ST_KEEP); // R6

    AST_RECONFIG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> state_q == ST_FLUSH); // R9

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        fs_tick |=> !fs_tick); // R7

    AST_TICK_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fs_tick |-> $past(samp_edge)); // R7

endmodule

// File: tb/dsd_port_select_tb.sv
module dsd_port_select_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    typedef struct packed {
        logic        path;
        logic        inv;
        logic        pm;
        logic [1:0]  rate;
        logic [31:0] lw;
        logic [31:0] rw;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 2'b00, 32'hA5C3_0F81, 32'h1234_5678},
        '{1'b1, 1'b0, 1'b0, 2'b01, 32'hDEAD_BEEF, 32'h0000_FFFF},
        '{1'b0, 1'b1, 1'b0, 2'b10, 32'h8000_0001, 32'h7FFF_FFFE},
        '{1'b1, 1'b1, 1'b1, 2'b00, 32'hC0FF_EE11, 32'h1357_9BDF},
        '{1'b0, 1'b0, 1'b1, 2'b11, 32'hFFFF_0000, 32'h0000_FFFF},
        '{1'b1, 1'b0, 1'b0, 2'b00, 32'h0F0F_F0F0, 32'h5555_AAAA}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic path = 1'b0, inv = 1'b0, pm = 1'b0;
    logic [1:0] rate = 2'b00;
    logic pc = 1'b0, pl = 1'b0, pr = 1'b0;
    logic g0c, g0l, g0r, g1c, g1l, g1r;
    logic [31:0] left_word, right_word;
    logic word_valid, fs_tick;

    int checks = 0, failures = 0;
    int vcnt = 0, tcnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Selected group carries the stream, the other carries its inverse
    assign g0c = path ? ~pc : pc;
    assign g0l = path ? ~pl : pl;
    assign g0r = path ? ~pr : pr;
    assign g1c = path ? pc : ~pc;
    assign g1l = path ? pl : ~pl;
    assign g1r = path ? pr : ~pr;

    dsd_port_select dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .path_sel   (path),
        .clk_invert (inv),
        .pm_mode    (pm),
        .rate_sel   (rate),
        .grp0_clk   (g0c),
        .grp0_left  (g0l),
        .grp0_right (g0r),
        .grp1_clk   (g1c),
        .grp1_left  (g1l),
        .grp1_right (g1r),
        .left_word  (left_word),
        .right_word (right_word),
        .word_valid (word_valid),
        .fs_tick    (fs_tick)
    );

    always @(negedge clk) begin
        if (rst_n && word_valid) vcnt++;
        if (rst_n && fs_tick)    tcnt++;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic p, input logic i, input logic m, input logic [1:0] rt);
        @(negedge clk);
        path = p; inv = i; pm = m; rate = rt;
        pc = i;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_bit(input logic l, input logic r, input bit chk,
                            input logic [31:0] el, input logic [31:0] er, input string tag);
        pc = inv; pl = l; pr = r;
        repeat (HALF) @(negedge clk);
        pc = ~inv;
        if (chk) begin
            repeat (2) @(posedge clk);
            #1 check(word_valid == 1'b0, {tag, " R5 early strobe"}, {31'd0, word_valid}, 32'd0);
            @(posedge clk);
            #1 check(word_valid == 1'b1, {tag, " R5 strobe due"}, {31'd0, word_valid}, 32'd1);
            check(left_word == el, {tag, " left word"}, left_word, el);
            check(right_word == er, {tag, " right word"}, right_word, er);
            @(negedge clk);
            repeat (HALF - 3) @(negedge clk);
        end else begin
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic send_word(input logic [31:0] l, input logic [31:0] r, input bit pmf, input string tag);
        int n;
        n = pmf ? 63 : 32;
        for (int pos = 0; pos < n; pos++) begin
            int idx;
            idx = pmf ? (pos + 1) / 2 : pos;
            send_bit(l[31-idx], r[31-idx], pos == n - 1, l, r, tag);
        end
    endtask

    task automatic send_fill(input int n);
        for (int k = 0; k < n; k++) send_bit(k[0], k[1] ^ k[3], 1'b0, '0, '0, "");
    endtask

    initial begin
        repeat (CLK_PERIOD) #1;
        while (checks < 0) #1;
    end

    initial begin
        int v0, t0;
        string tag;
        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(left_word == 32'd0, "R10 left after reset", left_word, 32'd0);
        check(right_word == 32'd0, "R10 right after reset", right_word, 32'd0);
        check(word_valid == 1'b0, "R10 strobe after reset", {31'd0, word_valid}, 32'd0);
        check(fs_tick == 1'b0, "R10 tick after reset", {31'd0, fs_tick}, 32'd0);

        // Vector table: routing (R1, R2), edge (R3), formats (R4, R6), strobe (R5)
        for (int v = 0; v < NVEC; v++) begin
            apply_cfg(VECS[v].path, VECS[v].inv, VECS[v].pm, VECS[v].rate);
            tag = $sformatf("vec%0d %s R3 %s", v, VECS[v].path ? "R2" : "R1", VECS[v].pm ? "R6" : "R4");
            v0 = vcnt;
            send_word(VECS[v].lw, VECS[v].rw, VECS[v].pm, tag);
            repeat (4) @(negedge clk);
            #1 check(vcnt == v0 + 1, {tag, " R5 one strobe per word"}, 32'(vcnt - v0), 32'd1);
        end

        // R7 / R8: tick spacing for each rate code over 256 edges
        for (int rc = 0; rc < 4; rc++) begin
            int exp_t;
            exp_t = (rc == 1) ? 2 : (rc == 2) ? 1 : 4;
            apply_cfg(1'b0, 1'b0, 1'b0, 2'(rc));
            t0 = tcnt; v0 = vcnt;
            send_fill(256);
            repeat (6) @(negedge clk);
            #1 check(tcnt - t0 == exp_t, (rc == 3) ? "R8 spare rate code ticks" : "R7 ticks per 256 edges",
                     32'(tcnt - t0), 32'(exp_t));
            check(vcnt - v0 == 8, "R4 words per 256 edges", 32'(vcnt - v0), 32'd8);
        end
        // R7 boundary: 256-ratio gives no tick before edge 256
        apply_cfg(1'b0, 1'b0, 1'b0, 2'b10);
        t0 = tcnt;
        send_fill(255);
        repeat (6) @(negedge clk);
        #1 check(tcnt == t0, "R7 no tick at 255 edges", 32'(tcnt - t0), 32'd0);

        // R9: reconfiguration discards partial word, holds last word
        apply_cfg(1'b0, 1'b0, 1'b0, 2'b00);
        send_word(32'h3C3C_1234, 32'hABCD_0F0F, 1'b0, "R9 base");
        send_fill(10);
        apply_cfg(1'b1, 1'b0, 1'b0, 2'b00);
        #1 check(left_word == 32'h3C3C_1234, "R9 left held", left_word, 32'h3C3C_1234);
        check(right_word == 32'hABCD_0F0F, "R9 right held", right_word, 32'hABCD_0F0F);
        v0 = vcnt;
        send_word(32'h9E37_79B9, 32'h6A09_E667, 1'b0, "R9 restart");
        repeat (4) @(negedge clk);
        #1 check(vcnt == v0 + 1, "R9 single word after restart", 32'(vcnt - v0), 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule